// File: doc/BRIEF.md
# False-Trigger Filter with Event Buffer

A trigger bank that uses masked comparisons can cover more trace-select (TS) values than the user asked for. The extra values are the "off-primes". This block sits behind such a bank and judges each trigger after it has fired. On each trigger it stores the TS value and the index of the trace segment being captured in a small first-in first-out event buffer. It then checks the oldest stored event against a programmable list of off-primes, one list entry per clock.

When an off-prime matches, the block reports that the segment holds a false trigger and can be reclaimed. When no entry matches, it reports a genuine trigger. Capture is never blocked. Off-prime patterns are loaded at configuration time as mask/value pairs, alongside the trigger unit settings.

A trigger that arrives while the buffer is full is lost, and the loss is recorded in a sticky flag. The buffer depth therefore has to be sized against the scan length and the shortest gap between triggers.

Top module: `false_trig_filter`

## Requirements
- R1: A cycle with `cfgWe` high stores `cfgMask`/`cfgValue` as off-prime entry `cfgIdx` (0..7). A cycle with `cfgCntWe` high sets the number of active entries from `cfgCnt`. Only entries 0..count-1 take part in a scan.
- R2: An entry matches a TS value when every bit set in its mask is equal between TS and the entry's value. Bits whose mask bit is 0 are ignored.
- R3: A `trigValid` cycle pushes {`trigTs`, `trigSeg`} into the event buffer if the buffer does not already hold DEPTH (default 2) events at that edge. Events are judged in arrival order.
- R4: The oldest event is compared with entry 0, 1, 2, ... on successive cycles. The scan stops at the first match. With the push at edge E0 and the event alone in the buffer, a match at entry j gives a result pulse with `resFalse`=1 after edge E0+j+1.
- R5: If none of the N active entries match, the result pulse carries `resFalse`=0 and appears after edge E0+N.
- R6: With an active count of 0, every event is reported genuine (`resFalse`=0) after edge E0+1.
- R7: Each accepted event produces exactly one result. `resValid` is high for one cycle, with `resSeg` equal to the event's segment index. `resValid` stays low while the buffer is empty.
- R8: A trigger that finds the buffer full is dropped and sets `overflow`. `overflow` then stays high until cleared.
- R9: `ovfClear` clears `overflow` at the next edge. When a dropped trigger and `ovfClear` occur in the same cycle, `overflow` is set.
- R10: After reset, `resValid`, `resFalse`, `resSeg` and `overflow` are 0, the buffer is empty and the active count is 0.
- R11: A written count above 8 is treated as 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Write strobe for one off-prime entry |
| cfgIdx | input | 3 | Entry index for the write |
| cfgMask | input | 8 | Care mask of the entry (1 = compare bit) |
| cfgValue | input | 8 | Pattern of the entry |
| cfgCntWe | input | 1 | Write strobe for the active count |
| cfgCnt | input | 4 | Number of active entries (clamped to 8) |
| trigValid | input | 1 | A trigger fired this cycle |
| trigTs | input | 8 | TS value that caused the trigger |
| trigSeg | input | 4 | Trace segment index of the capture |
| ovfClear | input | 1 | Clears the overflow flag |
| resValid | output | 1 | One-cycle result pulse |
| resSeg | output | 4 | Segment index of the judged event |
| resFalse | output | 1 | 1 = off-prime hit, the segment may be reused |
| overflow | output | 1 | Sticky flag set when a trigger was dropped |

## Verification
The result for a lone event is due a fixed number of edges after the push edge. That number is the index of the first matching entry plus one, the active count for a genuine event, or one when the count is 0. The bench holds the trigger for exactly one edge, then counts edges from that push and samples at each falling edge. It compares the edge count at which `resValid` first appears with the figure from R4 to R6, and checks that the pulse has gone one cycle later. The overflow flag is due at the edge of the rejected trigger, so the bench reads it at the falling edge that follows. It then drains the buffer over a window long enough for both queued scans of eight cycles each.

// File: rtl/ftf_pkg.sv
package ftf_pkg;

  // Strobes issued by the control to the datapath for one clock
  typedef struct packed {
    logic push;     // store incoming trigger
    logic pop;      // retire head event
    logic idxClr;   // restart scan at entry 0
    logic idxInc;   // advance scan to next entry
    logic resLoad;  // emit a result this edge
    logic resFalse; // verdict of the emitted result
    logic ovfSet;   // a trigger was dropped
  } ftfCtl_t;

endpackage

// File: rtl/ftf_offprimeTable.sv
module ftf_offprimeTable #(
  parameter int TS_W   = 8,
  parameter int MAX_OP = 8,
  localparam int IDX_W = (MAX_OP > 1) ? $clog2(MAX_OP) : 1,
  localparam int CNT_W = $clog2(MAX_OP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [TS_W-1:0]  wrMask,
  input  logic [TS_W-1:0]  wrValue,
  input  logic             cntWe,
  input  logic [CNT_W-1:0] cntIn,
  input  logic [IDX_W-1:0] rdIdx,
  input  logic [TS_W-1:0]  probeTs,
  output logic             hit,
  output logic             lastIdx,
  output logic             countZero
);

  logic [TS_W-1:0]  maskMem [MAX_OP];
  logic [TS_W-1:0]  valMem  [MAX_OP];
  logic [CNT_W-1:0] activeCnt;
  logic [TS_W-1:0]  selMask;
  logic [TS_W-1:0]  selVal;

  // One register pair per entry
  for (genvar e = 0; e < MAX_OP; e++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        maskMem[e] <= '0;
        valMem[e]  <= '0;
      end else if (wrEn && (wrIdx == IDX_W'(e))) begin
        maskMem[e] <= wrMask;
        valMem[e]  <= wrValue;
      end
    end
  end

  // Active count, saturated at the table size
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      activeCnt <= '0;
    end else if (cntWe) begin
      activeCnt <= (cntIn > CNT_W'(MAX_OP)) ? CNT_W'(MAX_OP) : cntIn;
    end
  end

  always_comb begin
    selMask   = maskMem[rdIdx];
    selVal    = valMem[rdIdx];
    hit       = ((probeTs ^ selVal) & selMask) == '0;
    lastIdx   = (CNT_W'(rdIdx) + CNT_W'(1)) >= activeCnt;
    countZero = (activeCnt == '0);
  end

endmodule

// File: rtl/ftf_eventFifo.sv
module ftf_eventFifo #(
  parameter int TS_W  = 8,
  parameter int SEG_W = 4,
  parameter int DEPTH = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [TS_W-1:0]  inTs,
  input  logic [SEG_W-1:0] inSeg,
  output logic [TS_W-1:0]  headTs,
  output logic [SEG_W-1:0] headSeg,
  output logic             empty,
  output logic             full
);

  logic [TS_W-1:0]  tsMem  [DEPTH];
  logic [SEG_W-1:0] segMem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [OCC_W-1:0] occ;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tsMem[s]  <= '0;
        segMem[s] <= '0;
      end else if (push && (wrPtr == PTR_W'(s))) begin
        tsMem[s]  <= inTs;
        segMem[s] <= inSeg;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      occ   <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      case ({push, pop})
        2'b10:   occ <= occ + OCC_W'(1);
        2'b01:   occ <= occ - OCC_W'(1);
        default: occ <= occ;
      endcase
    end
  end

  always_comb begin
    headTs  = tsMem[rdPtr];
    headSeg = segMem[rdPtr];
    empty   = (occ == '0);
    full    = (occ == OCC_W'(DEPTH));
  end

endmodule

// File: rtl/ftf_datapath.sv
module ftf_datapath
  import ftf_pkg::*;
#(
  parameter int TS_W   = 8,
  parameter int SEG_W  = 4,
  parameter int DEPTH  = 2,
  parameter int MAX_OP = 8,
  localparam int IDX_W = (MAX_OP > 1) ? $clog2(MAX_OP) : 1,
  localparam int CNT_W = $clog2(MAX_OP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ftfCtl_t          ctl,
  input  logic             cfgWe,
  input  logic [IDX_W-1:0] cfgIdx,
  input  logic [TS_W-1:0]  cfgMask,
  input  logic [TS_W-1:0]  cfgValue,
  input  logic             cfgCntWe,
  input  logic [CNT_W-1:0] cfgCnt,
  input  logic [TS_W-1:0]  trigTs,
  input  logic [SEG_W-1:0] trigSeg,
  input  logic             ovfClear,
  output logic             stEmpty,
  output logic             stFull,
  output logic             stHit,
  output logic             stLast,
  output logic             stCntZero,
  output logic             resValid,
  output logic [SEG_W-1:0] resSeg,
  output logic             resFalse,
  output logic             overflow
);

  logic [IDX_W-1:0] scanIdx;
  logic [TS_W-1:0]  headTs;
  logic [SEG_W-1:0] headSeg;

  ftf_eventFifo #(
    .TS_W (TS_W),
    .SEG_W(SEG_W),
    .DEPTH(DEPTH)
  ) u_fifo (
    .clk    (clk),
    .rst_n  (rst_n),
    .push   (ctl.push),
    .pop    (ctl.pop),
    .inTs   (trigTs),
    .inSeg  (trigSeg),
    .headTs (headTs),
    .headSeg(headSeg),
    .empty  (stEmpty),
    .full   (stFull)
  );

  ftf_offprimeTable #(
    .TS_W  (TS_W),
    .MAX_OP(MAX_OP)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrEn     (cfgWe),
    .wrIdx    (cfgIdx),
    .wrMask   (cfgMask),
    .wrValue  (cfgValue),
    .cntWe    (cfgCntWe),
    .cntIn    (cfgCnt),
    .rdIdx    (scanIdx),
    .probeTs  (headTs),
    .hit      (stHit),
    .lastIdx  (stLast),
    .countZero(stCntZero)
  );

  // Scan pointer into the off-prime list
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scanIdx <= '0;
    end else if (ctl.idxClr) begin
      scanIdx <= '0;
    end else if (ctl.idxInc) begin
      scanIdx <= scanIdx + IDX_W'(1);
    end
  end

  // Result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resValid <= 1'b0;
      resSeg   <= '0;
      resFalse <= 1'b0;
    end else begin
      resValid <= ctl.resLoad;
      if (ctl.resLoad) begin
        resSeg   <= headSeg;
        resFalse <= ctl.resFalse;
      end
    end
  end

  // Sticky overflow, setting has priority over clearing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overflow <= 1'b0;
    end else if (ctl.ovfSet) begin
      overflow <= 1'b1;
    end else if (ovfClear) begin
      overflow <= 1'b0;
    end
  end

endmodule

// File: rtl/ftf_ctrl.sv
module ftf_ctrl
  import ftf_pkg::*;
(
  input  logic    trigValid,
  input  logic    stEmpty,
  input  logic    stFull,
  input  logic    stHit,
  input  logic    stLast,
  input  logic    stCntZero,
  output ftfCtl_t ctl
);

  logic busy;
  logic finish;
  logic falseHit;

  always_comb begin
    busy     = !stEmpty;
    falseHit = !stCntZero && stHit;
    finish   = busy && (stCntZero || stHit || stLast);

    ctl          = '0;
    ctl.push     = trigValid && !stFull;
    ctl.ovfSet   = trigValid && stFull;
    ctl.resLoad  = finish;
    ctl.resFalse = falseHit;
    ctl.pop      = finish;
    ctl.idxClr   = finish;
    ctl.idxInc   = busy && !finish;
  end

endmodule

// File: rtl/false_trig_filter.sv
module false_trig_filter
  import ftf_pkg::*;
#(
  parameter int TS_W   = 8,
  parameter int SEG_W  = 4,
  parameter int DEPTH  = 2,
  parameter int MAX_OP = 8,
  localparam int IDX_W = (MAX_OP > 1) ? $clog2(MAX_OP) : 1,
  localparam int CNT_W = $clog2(MAX_OP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgWe,
  input  logic [IDX_W-1:0] cfgIdx,
  input  logic [TS_W-1:0]  cfgMask,
  input  logic [TS_W-1:0]  cfgValue,
  input  logic             cfgCntWe,
  input  logic [CNT_W-1:0] cfgCnt,
  input  logic             trigValid,
  input  logic [TS_W-1:0]  trigTs,
  input  logic [SEG_W-1:0] trigSeg,
  input  logic             ovfClear,
  output logic             resValid,
  output logic [SEG_W-1:0] resSeg,
  output logic             resFalse,
  output logic             overflow
);

  ftfCtl_t ctl;
  logic    stEmpty;
  logic    stFull;
  logic    stHit;
  logic    stLast;
  logic    stCntZero;

  ftf_ctrl u_ctrl (
    .trigValid(trigValid),
    .stEmpty  (stEmpty),
    .stFull   (stFull),
    .stHit    (stHit),
    .stLast   (stLast),
    .stCntZero(stCntZero),
    .ctl      (ctl)
  );

  ftf_datapath #(
    .TS_W  (TS_W),
    .SEG_W (SEG_W),
    .DEPTH (DEPTH),
    .MAX_OP(MAX_OP)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (ctl),
    .cfgWe    (cfgWe),
    .cfgIdx   (cfgIdx),
    .cfgMask  (cfgMask),
    .cfgValue (cfgValue),
    .cfgCntWe (cfgCntWe),
    .cfgCnt   (cfgCnt),
    .trigTs   (trigTs),
    .trigSeg  (trigSeg),
    .ovfClear (ovfClear),
    .stEmpty  (stEmpty),
    .stFull   (stFull),
    .stHit    (stHit),
    .stLast   (stLast),
    .stCntZero(stCntZero),
    .resValid (resValid),
    .resSeg   (resSeg),
    .resFalse (resFalse),
    .overflow (overflow)
  );

endmodule

// File: rtl/ftf_checker.sv
module ftf_checker (
  input logic clk,
  input logic rst_n,
  input logic trigValid,
  input logic ovfClear,
  input logic overflow,
  input logic resValid,
  input logic bufEmpty,
  input logic bufFull
);

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !ovfClear) |=> overflow); // R8

  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(trigValid)); // R8

  AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ovfClear && !trigValid) |=> !overflow); // R9

  AST_OVF_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ovfClear && trigValid && bufFull) |=> overflow); // R9

  AST_NO_RES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    bufEmpty |=> !resValid); // R7

endmodule

bind false_trig_filter ftf_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .trigValid(trigValid),
  .ovfClear (ovfClear),
  .overflow (overflow),
  .resValid (resValid),
  .bufEmpty (stEmpty),
  .bufFull  (stFull)
);

// File: tb/false_trig_filter_tb.sv
module false_trig_filter_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfgWe = 1'b0;
  logic [2:0] cfgIdx = '0;
  logic [7:0] cfgMask = '0;
  logic [7:0] cfgValue = '0;
  logic       cfgCntWe = 1'b0;
  logic [3:0] cfgCnt = '0;
  logic       trigValid = 1'b0;
  logic [7:0] trigTs = '0;
  logic [3:0] trigSeg = '0;
  logic       ovfClear = 1'b0;
  logic       resValid;
  logic [3:0] resSeg;
  logic       resFalse;
  logic       overflow;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int         gotLat;
  logic       gotFalse;
  logic [3:0] gotSeg;
  int         pulses;
  logic [3:0] pSeg [4];
  logic       pFalse [4];

  always #5 clk = ~clk;

  false_trig_filter u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfgWe    (cfgWe),
    .cfgIdx   (cfgIdx),
    .cfgMask  (cfgMask),
    .cfgValue (cfgValue),
    .cfgCntWe (cfgCntWe),
    .cfgCnt   (cfgCnt),
    .trigValid(trigValid),
    .trigTs   (trigTs),
    .trigSeg  (trigSeg),
    .ovfClear (ovfClear),
    .resValid (resValid),
    .resSeg   (resSeg),
    .resFalse (resFalse),
    .overflow (overflow)
  );

  typedef struct packed {
    logic [7:0] ts;
    logic       isFalse;
    logic [3:0] lat;
  } vec_t;

  // Entries: 0 = exact 0x0A, 1 = 0x3?, 2 = ?5, 3 = exact 0x35; count 4
  localparam vec_t VECS [7] = '{
    '{8'h0A, 1'b1, 4'd1},
    '{8'h3C, 1'b1, 4'd2},
    '{8'h35, 1'b1, 4'd2},
    '{8'h75, 1'b1, 4'd3},
    '{8'h77, 1'b0, 4'd4},
    '{8'h0B, 1'b0, 4'd4},
    '{8'hA5, 1'b1, 4'd3}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfgEntry(input logic [2:0] idx, input logic [7:0] m, input logic [7:0] v);
    @(negedge clk);
    cfgWe = 1'b1; cfgIdx = idx; cfgMask = m; cfgValue = v;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic setCount(input logic [3:0] c);
    @(negedge clk);
    cfgCntWe = 1'b1; cfgCnt = c;
    @(negedge clk);
    cfgCntWe = 1'b0;
  endtask

  // One trigger, then count edges after the push edge until the result shows
  task automatic runEvent(input logic [7:0] ts, input logic [3:0] seg);
    @(negedge clk);
    trigValid = 1'b1; trigTs = ts; trigSeg = seg;
    @(negedge clk);
    trigValid = 1'b0;
    gotLat = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      gotLat++;
      if (resValid) break;
    end
    gotFalse = resFalse;
    gotSeg   = resSeg;
  endtask

  task automatic collect(input int cycles);
    pulses = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (resValid && pulses < 4) begin
        pSeg[pulses]   = resSeg;
        pFalse[pulses] = resFalse;
        pulses++;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 resValid", 32'(resValid), 32'd0);
    chk("R10 resFalse", 32'(resFalse), 32'd0);
    chk("R10 resSeg", 32'(resSeg), 32'd0);
    chk("R10 overflow", 32'(overflow), 32'd0);

    // R1 load off-prime table, R2 masked patterns
    cfgEntry(3'd0, 8'hFF, 8'h0A);
    cfgEntry(3'd1, 8'hF0, 8'h30);
    cfgEntry(3'd2, 8'h0F, 8'h05);
    cfgEntry(3'd3, 8'hFF, 8'h35);
    setCount(4'd4);

    // R4 / R5 / R7 vector walk
    for (int i = 0; i < 7; i++) begin
      runEvent(VECS[i].ts, 4'(i + 1));
      chk(VECS[i].isFalse ? "R4 latency" : "R5 latency", 32'(gotLat), 32'(VECS[i].lat));
      chk(VECS[i].isFalse ? "R2 verdict" : "R5 verdict", 32'(gotFalse), 32'(VECS[i].isFalse));
      chk("R7 segment", 32'(gotSeg), 32'(i + 1));
      @(negedge clk);
      chk("R7 one-cycle pulse", 32'(resValid), 32'd0);
    end

    // R6 count zero: matching value still reported genuine after one edge
    setCount(4'd0);
    runEvent(8'h0A, 4'd9);
    chk("R6 latency", 32'(gotLat), 32'd1);
    chk("R6 verdict", 32'(gotFalse), 32'd0);

    // R11 count clamp: only entry 7 matches 0xEE
    cfgEntry(3'd4, 8'hFF, 8'h00);
    cfgEntry(3'd5, 8'hFF, 8'h00);
    cfgEntry(3'd6, 8'hFF, 8'h00);
    cfgEntry(3'd7, 8'hFF, 8'hEE);
    setCount(4'd15);
    runEvent(8'hEE, 4'd10);
    chk("R11 latency", 32'(gotLat), 32'd8);
    chk("R11 verdict", 32'(gotFalse), 32'd1);

    // R3 / R8 overflow: three back-to-back triggers, depth 2
    setCount(4'd8);
    @(negedge clk);
    trigValid = 1'b1; trigTs = 8'h77; trigSeg = 4'd1;
    @(negedge clk);
    trigSeg = 4'd2;
    @(negedge clk);
    trigSeg = 4'd3;
    @(negedge clk);
    trigValid = 1'b0;
    chk("R8 overflow set", 32'(overflow), 32'd1);
    collect(30);
    chk("R8 dropped event gives no result", 32'(pulses), 32'd2);
    chk("R3 order first", 32'(pSeg[0]), 32'd1);
    chk("R3 order second", 32'(pSeg[1]), 32'd2);
    chk("R5 queued verdict", 32'(pFalse[0] | pFalse[1]), 32'd0);
    chk("R8 sticky", 32'(overflow), 32'd1);

    // R9 clear
    @(negedge clk);
    ovfClear = 1'b1;
    @(negedge clk);
    ovfClear = 1'b0;
    chk("R9 cleared", 32'(overflow), 32'd0);

    // R9 set wins over clear
    @(negedge clk);
    trigValid = 1'b1; trigTs = 8'h77; trigSeg = 4'd4;
    @(negedge clk);
    trigSeg = 4'd5;
    @(negedge clk);
    trigSeg = 4'd6; ovfClear = 1'b1;
    @(negedge clk);
    trigValid = 1'b0; ovfClear = 1'b0;
    chk("R9 set wins", 32'(overflow), 32'd1);
    collect(30);
    chk("R3 second burst results", 32'(pulses), 32'd2);
    chk("R3 second burst order", 32'(pSeg[1]), 32'd5);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule